// File: doc/BRIEF.md
# Power Monitor Sampling Sequencer

This block drives a 12-bit converter through one measurement pass of a supply monitor. Each pass converts the input voltage and the load current, and the output voltage as well when that channel is enabled. Every channel takes either one sample or sixteen samples in a row. A sixteen-sample run is summed and then divided by sixteen. Once the averages are ready, the block multiplies the averaged voltage by the averaged current to get a power figure. It publishes the averages and the power together, and raises a valid flag with them.

On every publication the block also refreshes two peak-hold registers, one for current and one for input voltage. It adds the power figure into an energy accumulator. A rollover counter and a publication counter sit beside that accumulator, so software can derive the average power over any window. A pass runs once per start strobe in single-shot mode. In continuous mode passes follow one another with no gap, and the last completed result stays readable between updates. A clear strobe empties the peak registers and the energy state.

Top module: `pmseq_top`

## Requirements
- R1: A pass converts input voltage first (channel code 0), then load current (code 1), then output voltage (code 2) if enabled. Each channel takes all of its samples in a row. While `adc_req_o` is high and `adc_ack_i` is low, both the request and `adc_chan_o` hold; code 3 is never requested.
- R2: With single-sample averaging (`avg16_i`=0), each published channel value equals the one sample converted for that channel in the pass.
- R3: With sixteen-sample averaging (`avg16_i`=1), each published channel value equals the sum of its sixteen samples shifted right by four (truncated).
- R4: `res_pwr_o` equals the published input voltage times the published load current, as an unsigned 24-bit product. It appears only after the multiply latency, in the same cycle as the one-cycle `res_upd_o` strobe. `res_valid_o` is high from the first publication onward.
- R5: With `vout_en_i`=0 the output voltage channel is never requested, and `res_vout_o` publishes 0.
- R6: In single-shot mode a `start_i` pulse while idle runs exactly one pass. A `start_i` that arrives while a pass is running is ignored, so it causes no extra publication.
- R7: While `cont_i` is high, passes repeat back to back. A pass already begun when `cont_i` falls still completes. Published outputs change only together with `res_upd_o`.
- R8: `pk_vin_o` and `pk_iout_o` hold the largest input voltage and the largest load current published since the last clear.
- R9: Each publication adds the power into `en_acc_o` modulo 2^EN_W, increments `en_roll_o` when that sum wraps, and increments `en_cnt_o`.
- R10: `clear_i` zeroes both peak registers, `en_acc_o`, `en_roll_o` and `en_cnt_o` on the next edge. This holds even when a publication lands on the same edge.
- R11: After reset, no request is pending, `res_valid_o` is low, and all results, peaks and energy outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Single-shot pass request |
| cont_i | input | 1 | Continuous mode select |
| avg16_i | input | 1 | 1: sixteen samples per channel, 0: one sample |
| vout_en_i | input | 1 | Include the output voltage channel |
| clear_i | input | 1 | Clear peaks and energy state |
| adc_req_o | output | 1 | Conversion request to converter |
| adc_chan_o | output | 2 | Channel code of the requested conversion |
| adc_ack_i | input | 1 | Converter returns a sample this cycle |
| adc_data_i | input | DW (12) | Converted sample |
| res_valid_o | output | 1 | A result has been published |
| res_upd_o | output | 1 | One-cycle strobe on each publication |
| res_vin_o | output | DW | Averaged input voltage |
| res_iout_o | output | DW | Averaged load current |
| res_vout_o | output | DW | Averaged output voltage, 0 when disabled |
| res_pwr_o | output | 2*DW | Power product |
| pk_vin_o | output | DW | Peak input voltage |
| pk_iout_o | output | DW | Peak load current |
| en_acc_o | output | EN_W | Energy accumulator |
| en_roll_o | output | ROLL_W | Energy accumulator wrap count |
| en_cnt_o | output | CNT_W | Publications summed into energy |

## Verification
The assertions assume the converter acknowledges only while a request is pending. They also assume that `avg16_i` and `vout_en_i` hold steady whenever a pass may start. The bench models the converter so that it answers a request once, after a fixed delay, with a one-cycle acknowledge. It changes the mode inputs, and the data pattern the converter returns, only while the block is idle. The stimulus asserts `clear_i` either while the block is idle or across a whole pass. The pass that overlaps the clear is what exercises the clear winning over a same-edge publication.

// File: rtl/pmseq_pkg.sv
package pmseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_MUL  = 2'd2,
        ST_PUB  = 2'd3
    } seq_st_e;

    localparam logic [1:0] CH_VIN  = 2'd0;
    localparam logic [1:0] CH_IOUT = 2'd1;
    localparam logic [1:0] CH_VOUT = 2'd2;
    localparam int         NCH     = 3;

endpackage

// File: rtl/pmseq_chacc.sv
// Per-channel sample accumulator with divide-by-2^AVG_LOG readout.
module pmseq_chacc #(
    parameter int DW      = 12,
    parameter int AVG_LOG = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          add_i,
    input  logic          avg_many_i,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] avg_o
);
    localparam int SW = DW + AVG_LOG;

    logic [SW-1:0] sum_d, sum_q;

    always_comb begin
        sum_d = sum_q;
        if (clr_i) begin
            sum_d = '0;
        end else if (add_i) begin
            sum_d = sum_q + SW'(data_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    assign avg_o = avg_many_i ? sum_q[SW-1:AVG_LOG] : sum_q[DW-1:0];

endmodule

// File: rtl/pmseq_peak.sv
// Peak-hold register; clear wins over update.
module pmseq_peak #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          upd_i,
    input  logic [DW-1:0] val_i,
    output logic [DW-1:0] pk_o
);
    logic [DW-1:0] pk_d, pk_q;

    always_comb begin
        pk_d = pk_q;
        if (clr_i) begin
            pk_d = '0;
        end else if (upd_i && (val_i > pk_q)) begin
            pk_d = val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign pk_o = pk_q;

endmodule

// File: rtl/pmseq_energy.sv
// Energy accumulator with wrap counter and publication counter.
module pmseq_energy #(
    parameter int PW     = 24,
    parameter int EN_W   = 32,
    parameter int ROLL_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              add_i,
    input  logic [PW-1:0]     pwr_i,
    output logic [EN_W-1:0]   acc_o,
    output logic [ROLL_W-1:0] roll_o,
    output logic [CNT_W-1:0]  cnt_o
);
    typedef struct packed {
        logic [EN_W-1:0]   acc;
        logic [ROLL_W-1:0] roll;
        logic [CNT_W-1:0]  cnt;
    } en_t;

    en_t           en_d, en_q;
    logic [EN_W:0] sum_w;

    assign sum_w = {1'b0, en_q.acc} + (EN_W + 1)'(pwr_i);

    always_comb begin
        en_d = en_q;
        if (clr_i) begin
            en_d = '0;
        end else if (add_i) begin
            en_d.acc = sum_w[EN_W-1:0];
            en_d.cnt = en_q.cnt + 1'b1;
            if (sum_w[EN_W]) begin
                en_d.roll = en_q.roll + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign acc_o  = en_q.acc;
    assign roll_o = en_q.roll;
    assign cnt_o  = en_q.cnt;

endmodule

// File: rtl/pmseq_top.sv
module pmseq_top #(
    parameter int DW      = 12,
    parameter int AVG_LOG = 4,
    parameter int MUL_CYC = 3,
    parameter int EN_W    = 32,
    parameter int ROLL_W  = 8,
    parameter int CNT_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cont_i,
    input  logic              avg16_i,
    input  logic              vout_en_i,
    input  logic              clear_i,
    output logic              adc_req_o,
    output logic [1:0]        adc_chan_o,
    input  logic              adc_ack_i,
    input  logic [DW-1:0]     adc_data_i,
    output logic              res_valid_o,
    output logic              res_upd_o,
    output logic [DW-1:0]     res_vin_o,
    output logic [DW-1:0]     res_iout_o,
    output logic [DW-1:0]     res_vout_o,
    output logic [2*DW-1:0]   res_pwr_o,
    output logic [DW-1:0]     pk_vin_o,
    output logic [DW-1:0]     pk_iout_o,
    output logic [EN_W-1:0]   en_acc_o,
    output logic [ROLL_W-1:0] en_roll_o,
    output logic [CNT_W-1:0]  en_cnt_o
);
    import pmseq_pkg::*;

    localparam int PW  = 2 * DW;
    localparam int MCW = $clog2(MUL_CYC + 1);
    localparam logic [MCW-1:0]     MUL_LAST = MCW'(MUL_CYC - 1);
    localparam logic [AVG_LOG-1:0] SMP_MANY = {AVG_LOG{1'b1}};

    typedef struct packed {
        seq_st_e            st;
        logic [1:0]         ch;
        logic [AVG_LOG-1:0] smp;
        logic [MCW-1:0]     mcnt;
        logic               a16;
        logic               ven;
        logic               upd;
        logic               valid;
        logic [PW-1:0]      prod;
        logic [DW-1:0]      rvin;
        logic [DW-1:0]      riout;
        logic [DW-1:0]      rvout;
        logic [PW-1:0]      rpwr;
    } seq_t;

    seq_t q, n;

    logic              acc_clr;
    logic              req_w;
    logic              pub_w;
    logic [AVG_LOG-1:0] smp_last;
    logic [DW-1:0]     avg_w [NCH];
    logic [NCH-1:0]    add_w;

    assign smp_last = q.a16 ? SMP_MANY : '0;
    assign pub_w    = (q.st == ST_PUB);

    // ---------------- next-state logic ----------------
    always_comb begin
        n       = q;
        n.upd   = 1'b0;
        acc_clr = 1'b0;
        req_w   = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (cont_i || start_i) begin
                    n.st    = ST_CONV;
                    n.ch    = CH_VIN;
                    n.smp   = '0;
                    n.a16   = avg16_i;
                    n.ven   = vout_en_i;
                    acc_clr = 1'b1;
                end
            end
            ST_CONV: begin
                req_w = 1'b1;
                if (adc_ack_i) begin
                    if (q.smp == smp_last) begin
                        n.smp = '0;
                        if (q.ch == CH_VIN) begin
                            n.ch = CH_IOUT;
                        end else if ((q.ch == CH_IOUT) && q.ven) begin
                            n.ch = CH_VOUT;
                        end else begin
                            n.st   = ST_MUL;
                            n.mcnt = '0;
                        end
                    end else begin
                        n.smp = q.smp + 1'b1;
                    end
                end
            end
            ST_MUL: begin
                n.prod = PW'(avg_w[CH_VIN]) * PW'(avg_w[CH_IOUT]);
                if (q.mcnt == MUL_LAST) begin
                    n.st   = ST_PUB;
                    n.mcnt = '0;
                end else begin
                    n.mcnt = q.mcnt + 1'b1;
                end
            end
            ST_PUB: begin
                n.upd   = 1'b1;
                n.valid = 1'b1;
                n.rvin  = avg_w[CH_VIN];
                n.riout = avg_w[CH_IOUT];
                n.rvout = q.ven ? avg_w[CH_VOUT] : '0;
                n.rpwr  = q.prod;
                if (cont_i) begin
                    n.st    = ST_CONV;
                    n.ch    = CH_VIN;
                    n.smp   = '0;
                    n.a16   = avg16_i;
                    n.ven   = vout_en_i;
                    acc_clr = 1'b1;
                end else begin
                    n.st = ST_IDLE;
                end
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    // ---------------- channel accumulators ----------------
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign add_w[c] = (q.st == ST_CONV) && adc_ack_i && (q.ch == 2'(c));
        pmseq_chacc #(
            .DW      (DW),
            .AVG_LOG (AVG_LOG)
        ) u_acc (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr_i      (acc_clr),
            .add_i      (add_w[c]),
            .avg_many_i (q.a16),
            .data_i     (adc_data_i),
            .avg_o      (avg_w[c])
        );
    end

    // ---------------- peak hold ----------------
    logic [DW-1:0] pk_in [2];
    logic [DW-1:0] pk_out [2];
    assign pk_in[0] = avg_w[CH_VIN];
    assign pk_in[1] = avg_w[CH_IOUT];

    for (genvar p = 0; p < 2; p++) begin : g_pk
        pmseq_peak #(.DW(DW)) u_pk (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clear_i),
            .upd_i (pub_w),
            .val_i (pk_in[p]),
            .pk_o  (pk_out[p])
        );
    end

    // ---------------- energy ----------------
    pmseq_energy #(
        .PW     (PW),
        .EN_W   (EN_W),
        .ROLL_W (ROLL_W),
        .CNT_W  (CNT_W)
    ) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clear_i),
        .add_i  (pub_w),
        .pwr_i  (q.prod),
        .acc_o  (en_acc_o),
        .roll_o (en_roll_o),
        .cnt_o  (en_cnt_o)
    );

    // ---------------- outputs ----------------
    assign adc_req_o   = req_w;
    assign adc_chan_o  = q.ch;
    assign res_valid_o = q.valid;
    assign res_upd_o   = q.upd;
    assign res_vin_o   = q.rvin;
    assign res_iout_o  = q.riout;
    assign res_vout_o  = q.rvout;
    assign res_pwr_o   = q.rpwr;
    assign pk_vin_o    = pk_out[0];
    assign pk_iout_o   = pk_out[1];

endmodule

// File: rtl/pmseq_chk.sv
module pmseq_chk #(
    parameter int DW    = 12,
    parameter int CNT_W = 16,
    parameter int EN_W  = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            clear_i,
    input logic            adc_req_o,
    input logic [1:0]      adc_chan_o,
    input logic            adc_ack_i,
    input logic            res_valid_o,
    input logic            res_upd_o,
    input logic [2*DW-1:0] res_pwr_o,
    input logic [DW-1:0]   pk_vin_o,
    input logic [DW-1:0]   pk_iout_o,
    input logic [EN_W-1:0] en_acc_o,
    input logic [CNT_W-1:0] en_cnt_o
);
    assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_req_o && !adc_ack_i) |=> (adc_req_o && $stable(adc_chan_o)));

    assert_chan_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        adc_req_o |-> (adc_chan_o != 2'd3));

    assert_upd_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        res_upd_o |-> res_valid_o);

    assert_pwr_only_on_upd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res_pwr_o) |-> res_upd_o);

    assert_peak_i_mono_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (pk_iout_o >= $past(pk_iout_o)));

    assert_peak_v_mono_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (pk_vin_o >= $past(pk_vin_o)));

    assert_cnt_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> ((en_cnt_o != $past(en_cnt_o)) == res_upd_o));

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (pk_vin_o == '0 && pk_iout_o == '0 && en_acc_o == '0 && en_cnt_o == '0));

endmodule

bind pmseq_top pmseq_chk #(.DW(DW), .CNT_W(CNT_W), .EN_W(EN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (clear_i),
    .adc_req_o   (adc_req_o),
    .adc_chan_o  (adc_chan_o),
    .adc_ack_i   (adc_ack_i),
    .res_valid_o (res_valid_o),
    .res_upd_o   (res_upd_o),
    .res_pwr_o   (res_pwr_o),
    .pk_vin_o    (pk_vin_o),
    .pk_iout_o   (pk_iout_o),
    .en_acc_o    (en_acc_o),
    .en_cnt_o    (en_cnt_o)
);

// File: tb/pmseq_top_test.sv
`timescale 1ns/1ps
module pmseq_top_test;
    localparam int DW = 12;
    localparam int EW = 26;
    localparam int ADC_LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, cont_i = 0, avg16_i = 0, vout_en_i = 0, clear_i = 0;
    logic adc_req_o, adc_ack_i = 0;
    logic [1:0] adc_chan_o;
    logic [DW-1:0] adc_data_i = '0;
    logic res_valid_o, res_upd_o;
    logic [DW-1:0] res_vin_o, res_iout_o, res_vout_o, pk_vin_o, pk_iout_o;
    logic [2*DW-1:0] res_pwr_o;
    logic [EW-1:0] en_acc_o;
    logic [7:0] en_roll_o;
    logic [15:0] en_cnt_o;

    always #4 clk = ~clk;

    pmseq_top #(.EN_W(EW)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cont_i(cont_i),
        .avg16_i(avg16_i), .vout_en_i(vout_en_i), .clear_i(clear_i),
        .adc_req_o(adc_req_o), .adc_chan_o(adc_chan_o), .adc_ack_i(adc_ack_i),
        .adc_data_i(adc_data_i), .res_valid_o(res_valid_o), .res_upd_o(res_upd_o),
        .res_vin_o(res_vin_o), .res_iout_o(res_iout_o), .res_vout_o(res_vout_o),
        .res_pwr_o(res_pwr_o), .pk_vin_o(pk_vin_o), .pk_iout_o(pk_iout_o),
        .en_acc_o(en_acc_o), .en_roll_o(en_roll_o), .en_cnt_o(en_cnt_o)
    );

    int checks = 0, failures = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- converter model ----------------
    int adc_base [3];
    int adc_step [3];
    int n_model  [3];
    int chan_log [$];

    function automatic int adc_val(input int c, input int k);
        return (adc_base[c] + k * adc_step[c]) & 12'hFFF;
    endfunction

    initial begin
        int c;
        for (int i = 0; i < 3; i++) n_model[i] = 0;
        forever begin
            @(negedge clk);
            if (rst_n && adc_req_o) begin
                repeat (ADC_LAT) @(negedge clk);
                c = int'(adc_chan_o);
                adc_data_i = DW'(adc_val(c, n_model[c]));
                n_model[c]++;
                chan_log.push_back(c);
                adc_ack_i = 1'b1;
                @(negedge clk);
                adc_ack_i = 1'b0;
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        int vin, iout, vout, pwr, pkv, pki;
        longint acc;
        int roll, cnt;
        bit a16, ven, clr;
    } exp_t;

    exp_t expq [$];
    int pred_n [3];
    int m_pkv = 0, m_pki = 0, m_roll = 0, m_cnt = 0;
    longint m_acc = 0;
    int upd_cnt = 0;
    exp_t last_e;

    task automatic predict(input bit a16, input bit ven, input bit clr);
        exp_t e;
        int av [3];
        int ns = a16 ? 16 : 1;
        for (int c = 0; c < 3; c++) begin
            if (c < 2 || ven) begin
                int s = 0;
                for (int k = 0; k < ns; k++) begin
                    s += adc_val(c, pred_n[c]);
                    pred_n[c]++;
                end
                av[c] = a16 ? (s >> 4) : s;
            end else begin
                av[c] = 0;
            end
        end
        e.vin = av[0]; e.iout = av[1]; e.vout = av[2];
        e.pwr = av[0] * av[1];
        if (clr) begin
            m_pkv = 0; m_pki = 0; m_acc = 0; m_roll = 0; m_cnt = 0;
        end else begin
            if (av[0] > m_pkv) m_pkv = av[0];
            if (av[1] > m_pki) m_pki = av[1];
            m_acc += e.pwr;
            if (m_acc >= (64'd1 << EW)) begin
                m_acc -= (64'd1 << EW);
                m_roll = (m_roll + 1) % 256;
            end
            m_cnt = (m_cnt + 1) % 65536;
        end
        e.pkv = m_pkv; e.pki = m_pki; e.acc = m_acc; e.roll = m_roll; e.cnt = m_cnt;
        e.a16 = a16; e.ven = ven; e.clr = clr;
        expq.push_back(e);
    endtask

    always @(negedge clk) begin
        if (rst_n && res_upd_o) begin
            upd_cnt++;
            if (expq.size() == 0) begin
                chk(1'b0, "R6", "unexpected publication", 1, 0);
            end else begin
                exp_t e;
                string rv, re;
                e = expq.pop_front();
                last_e = e;
                rv = e.a16 ? "R3" : "R2";
                re = e.clr ? "R10" : "R9";
                chk(res_vin_o == DW'(e.vin), rv, "vin", res_vin_o, e.vin);
                chk(res_iout_o == DW'(e.iout), rv, "iout", res_iout_o, e.iout);
                chk(res_vout_o == DW'(e.vout), e.ven ? rv : "R5", "vout", res_vout_o, e.vout);
                chk(res_pwr_o == 24'(e.pwr), "R4", "power", res_pwr_o, e.pwr);
                chk(res_valid_o == 1'b1, "R4", "valid", res_valid_o, 1);
                chk(pk_vin_o == DW'(e.pkv), e.clr ? "R10" : "R8", "peak vin", pk_vin_o, e.pkv);
                chk(pk_iout_o == DW'(e.pki), e.clr ? "R10" : "R8", "peak iout", pk_iout_o, e.pki);
                chk(en_acc_o == EW'(e.acc), re, "energy", en_acc_o, e.acc);
                chk(en_roll_o == 8'(e.roll), re, "rollover", en_roll_o, e.roll);
                chk(en_cnt_o == 16'(e.cnt), re, "count", en_cnt_o, e.cnt);
            end
        end
    end

    task automatic wait_idle();
        while (expq.size() != 0) @(negedge clk);
        repeat (12) @(negedge clk);
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic set_data(input int b0, input int s0, input int b1, input int s1,
                            input int b2, input int s2);
        adc_base[0] = b0; adc_step[0] = s0;
        adc_base[1] = b1; adc_step[1] = s1;
        adc_base[2] = b2; adc_step[2] = s2;
    endtask

    task automatic one_shot(input bit a16, input bit ven);
        avg16_i = a16; vout_en_i = ven;
        predict(a16, ven, 1'b0);
        pulse_start();
        wait_idle();
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        int u0;
        for (int i = 0; i < 3; i++) pred_n[i] = 0;
        set_data(1000, 7, 300, 5, 900, 3);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk(adc_req_o == 1'b0, "R11", "req after reset", adc_req_o, 0);
        chk(res_valid_o == 1'b0, "R11", "valid after reset", res_valid_o, 0);
        chk(res_pwr_o == '0 && res_vin_o == '0, "R11", "results after reset", res_pwr_o, 0);
        chk(pk_vin_o == '0 && pk_iout_o == '0, "R11", "peaks after reset", pk_iout_o, 0);
        chk(en_acc_o == '0 && en_cnt_o == '0 && en_roll_o == '0, "R11", "energy after reset", en_acc_o, 0);

        // R2 R5: single sample, output voltage channel off
        one_shot(1'b0, 1'b0);
        chk(n_model[2] == 0, "R5", "vout conversions", n_model[2], 0);

        // R3 R1: sixteen samples, all channels, order check
        chan_log.delete();
        one_shot(1'b1, 1'b1);
        chk(chan_log.size() == 48, "R1", "conversion count", chan_log.size(), 48);
        begin
            int bad = 0;
            for (int i = 0; i < chan_log.size(); i++)
                if (chan_log[i] != i / 16) bad++;
            chk(bad == 0, "R1", "channel order errors", bad, 0);
        end

        // R7 hold between updates
        repeat (30) @(negedge clk);
        chk(res_pwr_o == 24'(last_e.pwr), "R7", "power held while idle", res_pwr_o, last_e.pwr);
        chk(res_vin_o == DW'(last_e.vin), "R7", "vin held while idle", res_vin_o, last_e.vin);

        // R6 start during busy ignored
        u0 = upd_cnt;
        avg16_i = 1'b0; vout_en_i = 1'b1;
        predict(1'b0, 1'b1, 1'b0);
        pulse_start();
        repeat (3) @(negedge clk);
        pulse_start();
        repeat (4) @(negedge clk);
        pulse_start();
        wait_idle();
        repeat (20) @(negedge clk);
        chk(upd_cnt - u0 == 1, "R6", "publications per busy start", upd_cnt - u0, 1);

        // R8 lower data: peaks must hold
        set_data(50, 1, 20, 2, 10, 1);
        one_shot(1'b0, 1'b1);
        one_shot(1'b1, 1'b0);

        // R7 continuous back to back
        set_data(2000, 11, 700, 13, 1500, 17);
        avg16_i = 1'b0; vout_en_i = 1'b1;
        u0 = upd_cnt;
        for (int i = 0; i < 5; i++) predict(1'b0, 1'b1, 1'b0);
        cont_i = 1'b1;
        while (upd_cnt - u0 < 4) @(negedge clk);
        cont_i = 1'b0;
        wait_idle();
        repeat (20) @(negedge clk);
        chk(upd_cnt - u0 == 5, "R7", "continuous publications", upd_cnt - u0, 5);

        // R10 clear while idle
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
        chk(pk_vin_o == '0 && pk_iout_o == '0, "R10", "peaks after clear", pk_vin_o, 0);
        chk(en_acc_o == '0 && en_cnt_o == '0 && en_roll_o == '0, "R10", "energy after clear", en_cnt_o, 0);
        m_pkv = 0; m_pki = 0; m_acc = 0; m_roll = 0; m_cnt = 0;

        // R10 clear overlapping a publication
        avg16_i = 1'b0; vout_en_i = 1'b0;
        predict(1'b0, 1'b0, 1'b1);
        clear_i = 1'b1;
        pulse_start();
        wait_idle();
        clear_i = 1'b0;
        @(negedge clk);

        // R9 rollover with full-scale data
        set_data(4095, 0, 4095, 0, 4095, 0);
        for (int i = 0; i < 6; i++) one_shot(1'b0, 1'b0);
        chk(en_roll_o == 8'(m_roll) && m_roll == 1, "R9", "rollover count", en_roll_o, 1);
        chk(en_cnt_o == 16'd6, "R9", "publication count", en_cnt_o, 6);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule